// File: doc/BRIEF.md
# Nonvolatile Store Sequencer

The sequencer decides whether a channel value that has just arrived over the serial port gets committed to nonvolatile storage. The serial front end reports three events, each as a one-cycle pulse: the edge where the start bit was taken (`start_i`), the edge where the last data bit was taken (`last_i`), and, alongside `last_i`, the assembled address and data. A store request is the level on `prog_i`. It is honoured only when it appears inside a short window that opens after the start bit and closes on the first clock edge after the last data bit.

When a request is honoured and the supply is good enough for programming, the sequencer pulls `rdy_o` low for a fixed number of serial clocks, which models the erase/write time. It also raises `lock_o` so that the front end ignores DI and keeps DO quiet. When that time ends, it issues a single write strobe to the storage model and carries the held address and data with it. If the supply is too low, the request is dropped: `rdy_o` stays high, and this tells the host that nothing was saved. A value that gets no request by the closing edge is forgotten, and the host must resend it to store it later.

Top module: `nv_store_seq`

## Requirements
- R1: After reset, rdy_o is 1, lock_o is 0 and wr_en_o is 0.
- R2: A store is requested when prog_i is high on any clock edge after the start edge, up to and including the edge one cycle after last_i. A level held only during cycles in between also counts, as long as it is sampled on at least one of those edges.
- R3: When a request is accepted with supply_ok_i high on the closing edge, rdy_o is low for exactly WRITE_CYC cycles, starting the cycle after the closing edge.
- R4: wr_en_o pulses high for exactly one cycle, in the first cycle with rdy_o high again. It carries the address and data taken on the last_i edge.
- R5: lock_o is high exactly when rdy_o is low. While busy, start_i, last_i and prog_i have no effect, and a frame sent during the busy period produces neither a second busy period nor a write.
- R6: If supply_ok_i is low on the closing edge, the request is rejected: rdy_o stays high and no write strobe follows.
- R7: prog_i raised only after the closing edge does not store the value. The held value is discarded.
- R8: A last_i pulse with no start_i before it in the same frame does not open a closing edge, so a prog_i request after it has no effect.
- R9: prog_i high only on the start edge itself is not a request.
- R10: A new frame may start two cycles after last_i, and it is handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock; must keep running through a store |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse on the edge the start bit was taken |
| last_i | input | 1 | Pulse on the edge the last data bit was taken |
| prog_i | input | 1 | Store request level |
| supply_ok_i | input | 1 | High when supply suffices for programming |
| addr_i | input | ADDR_W | Channel address, valid with last_i |
| data_i | input | DATA_W | Channel value, valid with last_i |
| rdy_o | output | 1 | High when ready; low during erase/write |
| lock_o | output | 1 | Front end must ignore DI and idle DO |
| wr_en_o | output | 1 | One-cycle write strobe to storage |
| wr_addr_o | output | ADDR_W | Address for the write |
| wr_data_o | output | DATA_W | Value for the write |

## Verification
The bench tests the exact edges of the request window. It raises PROG on the start edge alone, on the closing edge alone, and one cycle late. A design whose window is one cycle off would either store values the host meant to discard or miss requests made at the last legal edge. A second focus is the busy period: its length, which must be neither WRITE_CYC-1 nor WRITE_CYC+1, and whether a whole frame sent during it leaks into a second store. The bench also flips the supply flag on the closing edge, which catches a design that latches the request but ignores the supply gate, and sends back-to-back frames two cycles apart to catch state left over from an unstored frame.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  localparam int unsigned DEF_ADDR_W    = 1;
  localparam int unsigned DEF_DATA_W    = 8;
  localparam int unsigned DEF_WRITE_CYC = 16;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/nvs_window.sv
module nvs_window #(
  parameter int unsigned ADDR_W = 1,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic              last_i,
  input  logic              prog_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              take_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic armed_q, seen_q, due_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  // closing edge: one cycle after last bit
  assign take_o = en_i & due_q & (seen_q | prog_i);
  assign addr_o = addr_q;
  assign data_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      seen_q  <= 1'b0;
      due_q   <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      due_q <= en_i & armed_q & last_i & ~start_i;
      if (en_i) begin
        if (start_i) begin
          armed_q <= 1'b1;
          seen_q  <= 1'b0;
        end else if (armed_q) begin
          if (prog_i) seen_q <= 1'b1;
          if (last_i) begin
            armed_q <= 1'b0;
            addr_q  <= addr_i;
            data_q  <= data_i;
          end
        end
      end
    end
  end

  // R2
  take_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(last_i && en_i));
  // R5
  hold_while_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(addr_o) && $stable(data_o)));
endmodule

// File: rtl/nvs_timer.sv
module nvs_timer #(
  parameter int unsigned WRITE_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic supply_ok_i,
  output logic busy_o,
  output logic wr_o
);
  localparam int unsigned CNT_W = nvs_pkg::cnt_width(WRITE_CYC);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(WRITE_CYC);

  logic             busy_q, wr_q;
  logic [CNT_W-1:0] left_q;

  assign busy_o = busy_q;
  assign wr_o   = wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      left_q <= '0;
    end else begin
      wr_q <= 1'b0;
      if (busy_q) begin
        if (left_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          wr_q   <= 1'b1;
        end else begin
          left_q <= left_q - CNT_W'(1);
        end
      end else if (take_i && supply_ok_i) begin
        busy_q <= 1'b1;
        left_q <= LOAD;
      end
    end
  end

  // R3
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(take_i && supply_ok_i));
  // R4
  wr_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> ($past(busy_o) && !busy_o));
  // R6
  low_supply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !supply_ok_i && !busy_o) |=> !busy_o);
  // R3
  count_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (left_q != '0 && left_q <= LOAD));
endmodule

// File: rtl/nv_store_seq.sv
module nv_store_seq #(
  parameter int unsigned ADDR_W    = nvs_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W    = nvs_pkg::DEF_DATA_W,
  parameter int unsigned WRITE_CYC = nvs_pkg::DEF_WRITE_CYC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              last_i,
  input  logic              prog_i,
  input  logic              supply_ok_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              rdy_o,
  output logic              lock_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic busy, take;

  nvs_window #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (~busy),
    .start_i (start_i),
    .last_i  (last_i),
    .prog_i  (prog_i),
    .addr_i  (addr_i),
    .data_i  (data_i),
    .take_o  (take),
    .addr_o  (wr_addr_o),
    .data_o  (wr_data_o)
  );

  nvs_timer #(.WRITE_CYC(WRITE_CYC)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (take),
    .supply_ok_i (supply_ok_i),
    .busy_o      (busy),
    .wr_o        (wr_en_o)
  );

  assign rdy_o  = ~busy;
  assign lock_o = busy;

  // R4
  wr_when_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (rdy_o && !lock_o));
  // R5
  lock_vs_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o != rdy_o);
endmodule

// File: tb/tb_nv_store_seq.sv
module tb_nv_store_seq;
  localparam int AW = 1;
  localparam int DW = 8;
  localparam int W  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, last = 0, prog = 0, sup = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic rdy, lock, wr;
  logic [AW-1:0] wa;
  logic [DW-1:0] wd;

  int checks = 0, errors = 0, writes = 0, busy_len = 0;

  always #2 clk = ~clk;

  nv_store_seq #(.ADDR_W(AW), .DATA_W(DW), .WRITE_CYC(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .last_i(last), .prog_i(prog),
    .supply_ok_i(sup), .addr_i(addr), .data_i(data), .rdy_o(rdy), .lock_o(lock),
    .wr_en_o(wr), .wr_addr_o(wa), .wr_data_o(wd));

  // behavioural reference: frame phase tracked as integers
  int phase = 0;      // 0 idle, 1 inside frame, 2 closing edge next
  bit req = 0;
  int remain = 0;     // busy cycles left
  bit m_wr = 0;
  int m_addr = 0, m_data = 0, h_addr = 0, h_data = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase = 0; req = 0; remain = 0; m_wr = 0;
    end else begin
      m_wr = 0;
      if (remain > 0) begin
        remain = remain - 1;
        if (remain == 0) begin m_wr = 1; m_addr = h_addr; m_data = h_data; end
      end else begin
        if (phase == 2) begin
          if ((req || prog) && sup) remain = W;
          phase = 0;
        end
        if (start) begin phase = 1; req = 0; end
        else if (phase == 1) begin
          if (prog) req = 1;
          if (last) begin phase = 2; h_addr = int'(addr); h_data = int'(data); end
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the rising edge
  task automatic step();
    @(negedge clk);
    chk("R3 rdy_o", int'(rdy), (remain > 0) ? 0 : 1);
    chk("R5 lock_o", int'(lock), (remain > 0) ? 1 : 0);
    chk("R4 wr_en_o", int'(wr), int'(m_wr));
    if (m_wr) begin
      chk("R4 wr_addr_o", int'(wa), m_addr);
      chk("R4 wr_data_o", int'(wd), m_data);
    end
    if (wr) writes++;
    if (!rdy) busy_len++;
  endtask

  // mode: 0 none, 1 mid-frame pulse, 2 closing edge only, 3 late, 4 start edge only
  task automatic frame(input int a, input int d, input int mode, input bit s, input bit with_start);
    start = with_start; prog = (mode == 4); step();
    start = 0; prog = (mode == 1); step();
    prog = 0; step();
    last = 1; addr = AW'(a); data = DW'(d); step();
    last = 0; prog = (mode == 2); sup = s; step();
    prog = (mode == 3); sup = 1; step();
    prog = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic expect_store(input string tag, input int w0, input int exp_w, input int exp_len);
    chk({tag, " writes"}, writes - w0, exp_w);
    chk({tag, " busy length"}, busy_len, exp_len);
  endtask

  initial begin
    #(4ns * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int w0;
    #1;
    chk("R1 rdy_o in reset", int'(rdy), 1);
    chk("R1 lock_o in reset", int'(lock), 0);
    chk("R1 wr_en_o in reset", int'(wr), 0);
    #9 rst_n = 1;
    idle(3);

    // R2 mid-frame request, R3/R4 length and write
    w0 = writes; busy_len = 0;
    frame(1, 8'hA5, 1, 1, 1); idle(W + 3);
    expect_store("R2 R3 mid", w0, 1, W);

    // R2 request exactly on closing edge
    w0 = writes; busy_len = 0;
    frame(0, 8'h3C, 2, 1, 1); idle(W + 3);
    expect_store("R2 closing edge", w0, 1, W);

    // R6 low supply on closing edge
    w0 = writes; busy_len = 0;
    frame(1, 8'h77, 2, 0, 1); idle(4);
    expect_store("R6 low supply", w0, 0, 0);

    // R7 request one cycle late
    w0 = writes; busy_len = 0;
    frame(0, 8'h11, 3, 1, 1); idle(4);
    expect_store("R7 late prog", w0, 0, 0);

    // R9 request only on start edge
    w0 = writes; busy_len = 0;
    frame(1, 8'h22, 4, 1, 1); idle(4);
    expect_store("R9 start edge prog", w0, 0, 0);

    // R8 last without start
    w0 = writes; busy_len = 0;
    frame(1, 8'h33, 2, 1, 0); idle(4);
    expect_store("R8 no start", w0, 0, 0);

    // R10 back-to-back: unstored frame, then new start two cycles after last
    w0 = writes; busy_len = 0;
    start = 1; step(); start = 0; step();
    last = 1; addr = 1; data = 8'h44; step(); last = 0; step();
    frame(1, 8'h99, 2, 1, 1); idle(W + 3);
    expect_store("R10 back-to-back", w0, 1, W);

    // R5 frame sent during busy is ignored
    w0 = writes; busy_len = 0;
    frame(0, 8'h5A, 2, 1, 1);
    prog = 1; start = 1; step(); start = 0; step();
    last = 1; addr = 1; data = 8'hEE; step(); last = 0; step(); prog = 0;
    idle(W + 4);
    expect_store("R5 during busy", w0, 1, W);

    // R1 reset mid-busy returns to idle
    frame(1, 8'h0F, 2, 1, 1);
    @(negedge clk); rst_n = 0; #1;
    chk("R1 rdy_o after reset", int'(rdy), 1);
    chk("R1 lock_o after reset", int'(lock), 0);
    #3 rst_n = 1;
    idle(W + 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule